// File: doc/BRIEF.md
# UART Modem Control and Flow Gating Unit

This unit sits between a UART's FIFOs and its serial shifters. It keeps a 16-bit control register, a baud divisor register and a line-settings register. Software writes them over a single-cycle register bus and reads them back through a combinational data path. From the control bits it drives the active-low modem outputs. It decides whether the transmit shifter may start a new character, and whether the receive shifter should keep running. It also supplies the parity bit for the character being sent.

Transmit starts can be held off by a synchronized, active-low clear-to-send input. The request-to-send output can either follow a register bit or report receive FIFO space by itself. When receive is turned off, the shifter's current character is still allowed to finish. While the UART is enabled or either shifter is busy, the baud and line settings are protected. A write to them in that state is dropped, and a sticky error flag records it.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset the following hold: control reads 0x0200 (only the receive-enable bit set), baud reads BAUD_RST (default 1), line reads 0, the error flag is 0, rx_run is 0, and n_dtr, n_out1, n_out2 and n_rts are all 1.
- R2: The register addresses are 0 for control, 1 for baud, 2 for line and 3 for status (bit 0 is the error flag). Control bits are: 15 CTS flow enable, 14 RTS flow enable, 13 out2, 12 out1, 11 rts, 10 dtr, 9 receive enable, 0 UART enable. Unimplemented bits read 0.
- R3: n_dtr, n_out1 and n_out2 are the complements of control bits 10, 12 and 13. A write is visible on these outputs right after the edge that captures it.
- R4: n_rts is registered. It changes one edge after its inputs change. With bit 14 clear it equals the complement of bit 11. With bit 14 set it equals rx_fifo_full, so 0 requests data while space remains.
- R5: tx_start is high when tx_req is high, bit 0 is set, and either bit 15 is clear or the synchronized CTS is asserted. n_cts_in passes through two flops, so a change reaches tx_start two edges after it is applied.
- R6: rx_run goes high one edge after control holds both bit 0 and bit 9. Once either bit is cleared, rx_run stays high while rx_busy is high. It falls on the first edge at which rx_busy is low.
- R7: A write to baud (address 1) or line (address 2) is ignored while bit 0 is set, or while tx_busy or rx_busy is high. Otherwise the write takes effect on that edge.
- R8: Each ignored write sets the error flag. The flag stays set until a write to address 3 with bit 0 equal to 1.
- R9: The line register holds parity enable in bit 0, even select in bit 1, stick select in bit 2, and word length in bits 4:3 (5 plus the field's value, taking the lowest data bits). With parity disabled, parity_bit is 0. With parity enabled and stick select clear, parity_bit is the XOR of the used data bits, inverted when even select is 0.
- R10: With parity enabled and stick select set, parity_bit is 1 when even select is 0 and 0 when even select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| baud_div | output | 16 | Baud divisor to the baud generator |
| line_wlen | output | 2 | Word length code to the shifters |
| par_en | output | 1 | Parity enabled |
| lock_err | output | 1 | Sticky ignored-write flag |
| n_cts_in | input | 1 | Clear-to-send, active low, asynchronous |
| tx_req | input | 1 | Transmit shifter idle with a character waiting |
| tx_busy | input | 1 | Transmit shifter sending |
| tx_data | input | 8 | Character about to be sent |
| tx_start | output | 1 | Permission to start the character |
| parity_bit | output | 1 | Parity bit for tx_data |
| rx_busy | input | 1 | Receive shifter mid-character |
| rx_fifo_full | input | 1 | Receive FIFO has no free entry |
| rx_run | output | 1 | Receive shifter may run |
| n_rts | output | 1 | Request-to-send, active low |
| n_dtr | output | 1 | Data-terminal-ready, active low |
| n_out1 | output | 1 | Auxiliary output 1, active low |
| n_out2 | output | 1 | Auxiliary output 2, active low |

## Verification
The results arrive at different latencies. Register contents, reg_rdata, the modem outputs and parity_bit can all be seen at the falling edge that follows the capturing edge. n_rts and rx_run take one more edge. tx_start follows n_cts_in after two edges. The bench drives its inputs on falling edges and waits the exact number of edges for each result. It also checks CTS and the receive drop-off one edge early, so that a result that comes early is caught as well as one that comes late.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  localparam int REG_W    = 16;
  localparam int ADDR_W   = 2;
  localparam int WLEN_W   = 2;
  localparam int WORD_MIN = 5;

  // control bit positions
  localparam int B_CTSF = 15;
  localparam int B_RTSF = 14;
  localparam int B_OUT2 = 13;
  localparam int B_OUT1 = 12;
  localparam int B_RTS  = 11;
  localparam int B_DTR  = 10;
  localparam int B_RXE  = 9;
  localparam int B_EN   = 0;

  // line bit positions
  localparam int L_PEN  = 0;
  localparam int L_EPS  = 1;
  localparam int L_SPS  = 2;
  localparam int L_WLEN = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_BAUD = 2'd1,
    ADDR_LINE = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic cts_flow;
    logic rts_flow;
    logic out2;
    logic out1;
    logic rts;
    logic dtr;
    logic rxe;
    logic uart_en;
  } ctrl_t;

  typedef struct packed {
    logic              sps;
    logic              eps;
    logic              pen;
    logic [WLEN_W-1:0] wlen;
  } line_t;
endpackage

// File: rtl/ufc_regs.sv
module ufc_regs
  import uart_flow_pkg::*;
#(
  parameter logic [REG_W-1:0] BAUD_RST = 16'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              shifter_busy,
  output logic [REG_W-1:0]  rdata,
  output ctrl_t             ctrl,
  output line_t             line,
  output logic [REG_W-1:0]  baud,
  output logic              locked,
  output logic              err
);
  ctrl_t             ctrl_q, ctrl_d;
  line_t             line_q, line_d;
  logic [REG_W-1:0]  baud_q, baud_d;
  logic              err_q, err_d;

  assign locked = ctrl_q.uart_en | shifter_busy;

  always_comb begin
    ctrl_d = ctrl_q;
    line_d = line_q;
    baud_d = baud_q;
    err_d  = err_q;
    if (wr) begin
      case (reg_addr_e'(addr))
        ADDR_CTRL: begin
          ctrl_d.cts_flow = wdata[B_CTSF];
          ctrl_d.rts_flow = wdata[B_RTSF];
          ctrl_d.out2     = wdata[B_OUT2];
          ctrl_d.out1     = wdata[B_OUT1];
          ctrl_d.rts      = wdata[B_RTS];
          ctrl_d.dtr      = wdata[B_DTR];
          ctrl_d.rxe      = wdata[B_RXE];
          ctrl_d.uart_en  = wdata[B_EN];
        end
        ADDR_BAUD: begin
          if (locked) err_d = 1'b1;
          else        baud_d = wdata;
        end
        ADDR_LINE: begin
          if (locked) begin
            err_d = 1'b1;
          end else begin
            line_d.pen  = wdata[L_PEN];
            line_d.eps  = wdata[L_EPS];
            line_d.sps  = wdata[L_SPS];
            line_d.wlen = wdata[L_WLEN +: WLEN_W];
          end
        end
        ADDR_STAT: begin
          if (wdata[0]) err_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      ctrl_q.rxe <= 1'b1;
      line_q     <= '0;
      baud_q     <= BAUD_RST;
      err_q      <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      line_q <= line_d;
      baud_q <= baud_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      ADDR_CTRL: begin
        rdata[B_CTSF] = ctrl_q.cts_flow;
        rdata[B_RTSF] = ctrl_q.rts_flow;
        rdata[B_OUT2] = ctrl_q.out2;
        rdata[B_OUT1] = ctrl_q.out1;
        rdata[B_RTS]  = ctrl_q.rts;
        rdata[B_DTR]  = ctrl_q.dtr;
        rdata[B_RXE]  = ctrl_q.rxe;
        rdata[B_EN]   = ctrl_q.uart_en;
      end
      ADDR_BAUD: rdata = baud_q;
      ADDR_LINE: begin
        rdata[L_PEN]             = line_q.pen;
        rdata[L_EPS]             = line_q.eps;
        rdata[L_SPS]             = line_q.sps;
        rdata[L_WLEN +: WLEN_W]  = line_q.wlen;
      end
      ADDR_STAT: rdata[0] = err_q;
      default: ;
    endcase
  end

  assign ctrl = ctrl_q;
  assign line = line_q;
  assign baud = baud_q;
  assign err  = err_q;
endmodule

// File: rtl/ufc_flow.sv
module ufc_flow #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic cts_flow,
  input  logic rts_flow,
  input  logic rts_bit,
  input  logic n_cts_in,
  input  logic tx_req,
  input  logic rx_fifo_full,
  output logic tx_start,
  output logic n_rts
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   n_rts_q, n_rts_d;
  logic                   cts_ok;

  // synchronizer chain on the asserted-high form of CTS
  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = ~n_cts_in;
    end else begin : g_many
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], ~n_cts_in};
    end
  endgenerate

  assign n_rts_d = rts_flow ? rx_fifo_full : ~rts_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      n_rts_q <= 1'b1;
    end else begin
      sync_q  <= sync_d;
      n_rts_q <= n_rts_d;
    end
  end

  assign cts_ok   = ~cts_flow | sync_q[SYNC_STAGES-1];
  assign tx_start = tx_req & uart_en & cts_ok;
  assign n_rts    = n_rts_q;
endmodule

// File: rtl/ufc_rxgate.sv
module ufc_rxgate (
  input  logic clk,
  input  logic rst_n,
  input  logic uart_en,
  input  logic rxe,
  input  logic rx_busy,
  output logic rx_run
);
  logic run_q, run_d;

  // new enable starts at once; a drop waits for the character boundary
  assign run_d = (uart_en & rxe) | (run_q & rx_busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign rx_run = run_q;
endmodule

// File: rtl/ufc_parity.sv
module ufc_parity
  import uart_flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  line_t             line,
  output logic              parity_bit
);
  localparam int CNT_W = $clog2(DATA_W + 1) + 1;
  logic [CNT_W-1:0] nbits;
  logic [DATA_W-1:0] used;
  logic              xsum;

  assign nbits = CNT_W'(WORD_MIN) + CNT_W'(line.wlen);

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign used[i] = (CNT_W'(i) < nbits) ? data[i] : 1'b0;
    end
  endgenerate

  assign xsum = ^used;

  always_comb begin
    if (!line.pen)     parity_bit = 1'b0;
    else if (line.sps) parity_bit = ~line.eps;
    else               parity_bit = xsum ^ ~line.eps;
  end
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import uart_flow_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] BAUD_RST    = 16'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [REG_W-1:0]  baud_div,
  output logic [WLEN_W-1:0] line_wlen,
  output logic              par_en,
  output logic              lock_err,
  input  logic              n_cts_in,
  input  logic              tx_req,
  input  logic              tx_busy,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_start,
  output logic              parity_bit,
  input  logic              rx_busy,
  input  logic              rx_fifo_full,
  output logic              rx_run,
  output logic              n_rts,
  output logic              n_dtr,
  output logic              n_out1,
  output logic              n_out2
);
  ctrl_t ctrl;
  line_t line;
  logic  locked;
  logic  cts_flow, rts_flow, par_eps, par_sps;

  ufc_regs #(.BAUD_RST(BAUD_RST)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr           (reg_wr),
    .addr         (reg_addr),
    .wdata        (reg_wdata),
    .shifter_busy (tx_busy | rx_busy),
    .rdata        (reg_rdata),
    .ctrl         (ctrl),
    .line         (line),
    .baud         (baud_div),
    .locked       (locked),
    .err          (lock_err)
  );

  ufc_flow #(.SYNC_STAGES(SYNC_STAGES)) u_flow (
    .clk          (clk),
    .rst_n        (rst_n),
    .uart_en      (ctrl.uart_en),
    .cts_flow     (ctrl.cts_flow),
    .rts_flow     (ctrl.rts_flow),
    .rts_bit      (ctrl.rts),
    .n_cts_in     (n_cts_in),
    .tx_req       (tx_req),
    .rx_fifo_full (rx_fifo_full),
    .tx_start     (tx_start),
    .n_rts        (n_rts)
  );

  ufc_rxgate u_rxgate (
    .clk     (clk),
    .rst_n   (rst_n),
    .uart_en (ctrl.uart_en),
    .rxe     (ctrl.rxe),
    .rx_busy (rx_busy),
    .rx_run  (rx_run)
  );

  ufc_parity #(.DATA_W(DATA_W)) u_parity (
    .data       (tx_data),
    .line       (line),
    .parity_bit (parity_bit)
  );

  assign n_dtr     = ~ctrl.dtr;
  assign n_out1    = ~ctrl.out1;
  assign n_out2    = ~ctrl.out2;
  assign line_wlen = line.wlen;
  assign par_en    = line.pen;
  assign cts_flow  = ctrl.cts_flow;
  assign rts_flow  = ctrl.rts_flow;
  assign par_eps   = line.eps;
  assign par_sps   = line.sps;
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_wdata,
  input logic        n_dtr,
  input logic        n_out1,
  input logic        n_out2,
  input logic        n_cts_in,
  input logic        tx_start,
  input logic        cts_flow,
  input logic        rts_flow,
  input logic        n_rts,
  input logic        rx_fifo_full,
  input logic        rx_run,
  input logic        rx_busy,
  input logic        locked,
  input logic [15:0] baud_div,
  input logic        lock_err,
  input logic        parity_bit,
  input logic        par_en,
  input logic        par_eps,
  input logic        par_sps
);
  a_r3_modem_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=>
      (n_dtr == !$past(reg_wdata[10]) && n_out1 == !$past(reg_wdata[12]) &&
       n_out2 == !$past(reg_wdata[13])));

  a_r4_rts_flow: assert property (@(posedge clk) disable iff (!rst_n)
    rts_flow |=> (n_rts == $past(rx_fifo_full)));

  a_r5_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && cts_flow && $past(rst_n, 2)) |-> !$past(n_cts_in, 2));

  a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_run && rx_busy) |=> rx_run);

  a_r6_fall_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_run) |-> !$past(rx_busy));

  a_r7_baud_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1 && locked) |=> $stable(baud_div));

  a_r8_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == 2'd1 || reg_addr == 2'd2) && locked) |=> lock_err);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> lock_err);

  a_r10_stick: assert property (@(posedge clk) disable iff (!rst_n)
    (par_en && par_sps) |-> (parity_bit == !par_eps));
endmodule

bind uart_flow_ctl uart_flow_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .n_dtr        (n_dtr),
  .n_out1       (n_out1),
  .n_out2       (n_out2),
  .n_cts_in     (n_cts_in),
  .tx_start     (tx_start),
  .cts_flow     (cts_flow),
  .rts_flow     (rts_flow),
  .n_rts        (n_rts),
  .rx_fifo_full (rx_fifo_full),
  .rx_run       (rx_run),
  .rx_busy      (rx_busy),
  .locked       (locked),
  .baud_div     (baud_div),
  .lock_err     (lock_err),
  .parity_bit   (parity_bit),
  .par_en       (par_en),
  .par_eps      (par_eps),
  .par_sps      (par_sps)
);

// File: tb/tb_uart_flow_ctl.sv
module tb_uart_flow_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 20000;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata, baud_div;
  logic [1:0]  line_wlen;
  logic        par_en, lock_err, n_cts_in, tx_req, tx_busy;
  logic [7:0]  tx_data;
  logic        tx_start, parity_bit, rx_busy, rx_fifo_full, rx_run;
  logic        n_rts, n_dtr, n_out1, n_out2;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  uart_flow_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .baud_div(baud_div),
    .line_wlen(line_wlen), .par_en(par_en), .lock_err(lock_err),
    .n_cts_in(n_cts_in), .tx_req(tx_req), .tx_busy(tx_busy), .tx_data(tx_data),
    .tx_start(tx_start), .parity_bit(parity_bit), .rx_busy(rx_busy),
    .rx_fifo_full(rx_fifo_full), .rx_run(rx_run), .n_rts(n_rts),
    .n_dtr(n_dtr), .n_out1(n_out1), .n_out2(n_out2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [15:0] exp);
    reg_addr = a;
    #1;
    check(req, {16'd0, reg_rdata}, {16'd0, exp});
  endtask

  function automatic logic exp_par(input logic [7:0] d, input logic [15:0] ln);
    logic x;
    int n;
    n = 5 + int'(ln[4:3]);
    x = 1'b0;
    for (int i = 0; i < n; i++) x ^= d[i];
    if (!ln[0])     return 1'b0;
    else if (ln[2]) return !ln[1];
    else            return x ^ !ln[1];
  endfunction

  initial begin
    repeat (WDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] c, ln, b_keep;
    void'($urandom(32'd2417));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    n_cts_in = 1'b1; tx_req = 1'b0; tx_busy = 1'b0; tx_data = '0;
    rx_busy = 1'b0; rx_fifo_full = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd_check("R1 ctrl", 2'd0, 16'h0200);
    rd_check("R1 baud", 2'd1, 16'd1);
    rd_check("R1 line", 2'd2, 16'd0);
    check("R1 err", lock_err, 0);
    check("R1 rx_run", rx_run, 0);
    check("R1 modem", {n_dtr, n_out1, n_out2, n_rts}, 4'hF);

    // R2/R3/R4 random control values, flow and enable kept off
    for (int k = 0; k < 20; k++) begin
      c = 16'($urandom) & 16'h3E00;
      wr(2'd0, c);
      rd_check("R2 ctrl readback", 2'd0, c);
      check("R3 n_dtr", n_dtr, !c[10]);
      check("R3 n_out1", n_out1, !c[12]);
      check("R3 n_out2", n_out2, !c[13]);
      @(negedge clk);
      check("R4 n_rts no flow", n_rts, !c[11]);
    end
    wr(2'd0, 16'hFFFF);
    rd_check("R2 unimplemented bits", 2'd0, 16'hFE01);
    wr(2'd0, 16'h0000);

    // R4 RTS flow control
    wr(2'd0, 16'h4800);
    for (int k = 0; k < 16; k++) begin
      rx_fifo_full = 1'($urandom);
      @(negedge clk);
      check("R4 n_rts flow", n_rts, rx_fifo_full);
    end
    rx_fifo_full = 1'b0;

    // R5 CTS gating
    tx_req = 1'b1;
    wr(2'd0, 16'h0001);
    check("R5 no cts flow", tx_start, 1);
    wr(2'd0, 16'h8001);
    check("R5 cts deasserted", tx_start, 0);
    n_cts_in = 1'b0;
    @(negedge clk);
    check("R5 sync one edge", tx_start, 0);
    @(negedge clk);
    check("R5 sync two edges", tx_start, 1);
    n_cts_in = 1'b1;
    @(negedge clk);
    check("R5 drop one edge", tx_start, 1);
    @(negedge clk);
    check("R5 drop two edges", tx_start, 0);
    tx_req = 1'b0;
    @(negedge clk);
    check("R5 no request", tx_start, 0);
    wr(2'd0, 16'h0000);

    // R6 receive gating
    wr(2'd0, 16'h0201);
    check("R6 not yet", rx_run, 0);
    @(negedge clk);
    check("R6 run", rx_run, 1);
    rx_busy = 1'b1;
    wr(2'd0, 16'h0001);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R6 hold busy", rx_run, 1);
    end
    rx_busy = 1'b0;
    @(negedge clk);
    check("R6 stop at boundary", rx_run, 0);
    wr(2'd0, 16'h0200);
    @(negedge clk);
    check("R6 disabled uart", rx_run, 0);

    // R7/R8 locking
    wr(2'd1, 16'h0123);
    rd_check("R7 baud free", 2'd1, 16'h0123);
    check("R8 no err", lock_err, 0);
    b_keep = 16'h0123;
    for (int k = 0; k < 12; k++) begin
      case ($urandom % 3)
        0: begin wr(2'd0, 16'h0001); end
        1: begin tx_busy = 1'b1; end
        default: begin rx_busy = 1'b1; end
      endcase
      wr(2'd1, 16'($urandom));
      rd_check("R7 baud locked", 2'd1, b_keep);
      wr(2'd2, 16'h001F);
      rd_check("R7 line locked", 2'd2, 16'h0000);
      check("R8 err set", lock_err, 1);
      tx_busy = 1'b0; rx_busy = 1'b0;
      wr(2'd0, 16'h0000);
    end
    wr(2'd1, 16'h0456);
    rd_check("R7 unlocked write", 2'd1, 16'h0456);
    check("R8 err sticky", lock_err, 1);
    wr(2'd3, 16'h0000);
    check("R8 no clear on zero", lock_err, 1);
    wr(2'd3, 16'h0001);
    check("R8 cleared", lock_err, 0);
    rd_check("R8 status read", 2'd3, 16'h0000);

    // R9/R10 parity
    for (int k = 0; k < 60; k++) begin
      ln = 16'($urandom) & 16'h001F;
      if (k < 4) ln = 16'h0005 | 16'(k[0] << 1) | 16'(k[1] << 3);
      wr(2'd2, ln);
      tx_data = 8'($urandom);
      #1;
      if (ln[0] && ln[2]) check("R10 stick parity", parity_bit, exp_par(tx_data, ln));
      else                check("R9 parity", parity_bit, exp_par(tx_data, ln));
    end
    wr(2'd2, 16'h0001);
    tx_data = 8'b1110_0000;
    #1;
    check("R9 5-bit word ignores upper", parity_bit, 1);
    wr(2'd2, 16'h0019);
    #1;
    check("R9 8-bit word", parity_bit, 0);

    finish_run();
  end
endmodule